// File: doc/BRIEF.md
# Scaled-Index Load Fusion Detector

This unit sits between instruction fetch/decode and register rename. Each cycle it inspects a window of three consecutive 32-bit instructions. It looks for a three-step idiom that computes an array element address by hand and then loads from it. The steps are: shift the index left by two, add the shifted index to a base pointer, then load a word from the sum with no displacement. When the three instructions form a correct dependency chain, the unit replaces them with one scaled-index load micro-op. That op names the load destination, the base register, the index register and the shift amount. It also names the two intermediate destination registers, so the register updates made by the original sequence are still carried out.

When the window does not hold the idiom, the oldest slot passes through unchanged. The unit reports that one instruction was used, so the front end advances by one. After a fusion it reports three. All results are registered: they appear one clock after the window is presented.

The reset input is asynchronous and active low. Its release is synchronised inside the block, so outputs stay cleared for two rising edges after `rst_n` goes high.

Top module: `fuse_detector`

## Requirements
- R1: Slot 0 qualifies as the shift step only if bits [6:0]=0010011, bits [14:12]=001, bits [31:26]=000000 and the shift amount in bits [25:20] equals SCALE_SHAMT (default 2). Any other shift amount blocks fusion.
- R2: Slot 1 qualifies as the add step only if bits [6:0]=0110011, bits [14:12]=000 and bits [31:25]=0000000. The shifted index may appear as either the first source (bits [19:15]) or the second source (bits [24:20]). The other source becomes the fused base register.
- R3: Slot 2 qualifies as the load step only if bits [6:0]=0000011, bits [14:12]=010 and the offset in bits [31:20] is zero. Its address register (bits [19:15]) must equal the add destination (bits [11:7] of slot 1).
- R4: Fusion requires that one add source equals the shift destination (bits [11:7] of slot 0).
- R5: Fusion is blocked when the shift destination or the add destination is register 0.
- R6: Fusion is blocked when the base register equals the shift destination. This includes the case where both add sources name the shift destination.
- R7: Fusion happens only when all three slot valid bits are set in the same cycle.
- R8: One cycle after a window is presented, `out_vld` equals slot 0's valid bit. `out_consumed` is 3 after a fusion, 1 for a valid unfused slot 0, and 0 when slot 0 is invalid.
- R9: When slot 0 is valid and no fusion happens, `out_insn` carries slot 0 unchanged. Otherwise `out_insn` is zero. All fused-op fields and write enables are zero whenever `out_fused` is low.
- R10: On fusion, the fields are set as follows:
  - load destination: the load's bits [11:7];
  - base: the non-index add source;
  - index: the shift source;
  - shift amount: the decoded shift amount;
  - index destination: the shift destination;
  - sum destination: the add destination.
- R11: On fusion, `out_idx_wen` is 1 only if the index destination differs from both the sum destination and the load destination. `out_sum_wen` is 1 only if the sum destination differs from the load destination. A later write to the same register therefore takes precedence.
- R12: While reset is held, and for two rising edges after its release, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 3 | Valid bit per window slot (bit 0 = oldest) |
| in_insn0 | input | 32 | Oldest instruction in the window |
| in_insn1 | input | 32 | Second instruction |
| in_insn2 | input | 32 | Third instruction |
| out_vld | output | 1 | Registered slot 0 valid |
| out_fused | output | 1 | A fused scaled-index load is presented |
| out_consumed | output | 2 | Instructions taken from the window (0, 1 or 3) |
| out_insn | output | 32 | Pass-through instruction when not fused |
| out_ld_rd | output | 5 | Fused load destination |
| out_base | output | 5 | Fused base register |
| out_idx | output | 5 | Fused index register |
| out_shamt | output | 6 | Fused index shift amount |
| out_idx_rd | output | 5 | Register receiving the shifted index |
| out_sum_rd | output | 5 | Register receiving the computed address |
| out_idx_wen | output | 1 | Write enable for the shifted-index result |
| out_sum_wen | output | 1 | Write enable for the address result |

## Verification
Every result passes through exactly one register. A window driven after a falling edge is therefore checked 1 ns after the next rising edge, and the next window is driven only after that sample. Reset is checked in two phases:
- while `rst_n` is low, with a fusable window applied;
- across the two edges after release, during which outputs must stay clear.

The bench then checks on the first edge after that, where the result must appear. The main sweep covers every combination of a small register set across the chain positions, both add operand orders, and both load destinations. Expected values are computed arithmetically from the field values.

// File: rtl/fuse_pkg.sv
package fuse_pkg;

  localparam int unsigned ILEN   = 32;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned SHW    = 6;
  localparam int unsigned NSLOT  = 3;
  localparam int unsigned CNT_W  = $clog2(NSLOT + 1);

  localparam logic [6:0] OPC_OPIMM = 7'b0010011;
  localparam logic [6:0] OPC_OPREG = 7'b0110011;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [2:0] F3_SHL    = 3'b001;
  localparam logic [2:0] F3_ADD    = 3'b000;
  localparam logic [2:0] F3_WORD   = 3'b010;

  typedef logic [RIDX_W-1:0] ridx_t;

  typedef struct packed {
    logic           is_shl;
    logic           is_add;
    logic           is_ldw;
    ridx_t          rd;
    ridx_t          rs1;
    ridx_t          rs2;
    logic [SHW-1:0] shamt;
  } slot_dec_t;

  typedef struct packed {
    ridx_t          ld_rd;
    ridx_t          base;
    ridx_t          idx;
    logic [SHW-1:0] shamt;
    ridx_t          idx_rd;
    ridx_t          sum_rd;
    logic           idx_wen;
    logic           sum_wen;
  } fused_uop_t;

endpackage

// File: rtl/fuse_slot_decode.sv
module fuse_slot_decode
  import fuse_pkg::*;
(
  input  logic [ILEN-1:0] insn,
  output slot_dec_t       dec
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [5:0] f6;
  logic [11:0] imm_i;

  always_comb begin
    opc   = insn[6:0];
    f3    = insn[14:12];
    f7    = insn[31:25];
    f6    = insn[31:26];
    imm_i = insn[31:20];

    dec.rd    = insn[11:7];
    dec.rs1   = insn[19:15];
    dec.rs2   = insn[24:20];
    dec.shamt = insn[25:20];

    dec.is_shl = (opc == OPC_OPIMM) && (f3 == F3_SHL)  && (f6 == 6'd0);
    dec.is_add = (opc == OPC_OPREG) && (f3 == F3_ADD)  && (f7 == 7'd0);
    dec.is_ldw = (opc == OPC_LOAD)  && (f3 == F3_WORD) && (imm_i == 12'd0);
  end

endmodule

// File: rtl/fuse_chain_match.sv
module fuse_chain_match
  import fuse_pkg::*;
#(
  parameter int unsigned SCALE_SHAMT = 2
) (
  input  logic [NSLOT-1:0] vld,
  input  slot_dec_t        dec_shl,
  input  slot_dec_t        dec_add,
  input  slot_dec_t        dec_ldw,
  output logic             hit,
  output fused_uop_t       uop
);

  logic  idx_on_rs1;
  logic  idx_on_rs2;
  logic  add_chained;
  logic  ldw_chained;
  logic  base_clash;
  logic  zero_dest;
  logic  shift_ok;
  logic  kinds_ok;
  ridx_t base_sel;

  always_comb begin
    idx_on_rs1  = (dec_add.rs1 == dec_shl.rd);
    idx_on_rs2  = (dec_add.rs2 == dec_shl.rd);
    add_chained = idx_on_rs1 | idx_on_rs2;
    base_sel    = idx_on_rs1 ? dec_add.rs2 : dec_add.rs1;
    base_clash  = (base_sel == dec_shl.rd);
    ldw_chained = (dec_ldw.rs1 == dec_add.rd);
    zero_dest   = (dec_shl.rd == '0) | (dec_add.rd == '0);
    shift_ok    = (dec_shl.shamt == SHW'(SCALE_SHAMT));
    kinds_ok    = dec_shl.is_shl & dec_add.is_add & dec_ldw.is_ldw;

    hit = (&vld) & kinds_ok & shift_ok & add_chained & ldw_chained
        & ~base_clash & ~zero_dest;

    uop = '0;
    if (hit) begin
      uop.ld_rd   = dec_ldw.rd;
      uop.base    = base_sel;
      uop.idx     = dec_shl.rs1;
      uop.shamt   = dec_shl.shamt;
      uop.idx_rd  = dec_shl.rd;
      uop.sum_rd  = dec_add.rd;
      uop.idx_wen = (dec_shl.rd != dec_add.rd) && (dec_shl.rd != dec_ldw.rd);
      uop.sum_wen = (dec_add.rd != dec_ldw.rd);
    end
  end

  logic unused_fields;
  assign unused_fields = ^{dec_shl.is_add, dec_shl.is_ldw, dec_shl.rs2,
                           dec_add.is_shl, dec_add.is_ldw, dec_add.shamt,
                           dec_ldw.is_shl, dec_ldw.is_add, dec_ldw.rs2,
                           dec_ldw.shamt};

endmodule

// File: rtl/fuse_detector.sv
module fuse_detector
  import fuse_pkg::*;
#(
  parameter int unsigned SCALE_SHAMT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLOT-1:0]  in_vld,
  input  logic [ILEN-1:0]   in_insn0,
  input  logic [ILEN-1:0]   in_insn1,
  input  logic [ILEN-1:0]   in_insn2,
  output logic              out_vld,
  output logic              out_fused,
  output logic [CNT_W-1:0]  out_consumed,
  output logic [ILEN-1:0]   out_insn,
  output logic [RIDX_W-1:0] out_ld_rd,
  output logic [RIDX_W-1:0] out_base,
  output logic [RIDX_W-1:0] out_idx,
  output logic [SHW-1:0]    out_shamt,
  output logic [RIDX_W-1:0] out_idx_rd,
  output logic [RIDX_W-1:0] out_sum_rd,
  output logic              out_idx_wen,
  output logic              out_sum_wen
);

  // Reset release synchroniser
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Per-slot decode
  logic [ILEN-1:0] win [NSLOT];
  slot_dec_t       dec [NSLOT];

  assign win[0] = in_insn0;
  assign win[1] = in_insn1;
  assign win[2] = in_insn2;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    fuse_slot_decode u_dec (
      .insn (win[s]),
      .dec  (dec[s])
    );
  end

  // Chain match
  logic       hit;
  fused_uop_t uop;

  fuse_chain_match #(.SCALE_SHAMT(SCALE_SHAMT)) u_match (
    .vld     (in_vld),
    .dec_shl (dec[0]),
    .dec_add (dec[1]),
    .dec_ldw (dec[2]),
    .hit     (hit),
    .uop     (uop)
  );

  // Next state
  logic             vld_d,   vld_q;
  logic             fused_d, fused_q;
  logic [CNT_W-1:0] cnt_d,   cnt_q;
  logic [ILEN-1:0]  insn_d,  insn_q;
  fused_uop_t       uop_d,   uop_q;
  logic             upd_en;

  always_comb begin
    vld_d   = in_vld[0];
    fused_d = hit;
    uop_d   = uop;
    if (hit)            cnt_d = CNT_W'(NSLOT);
    else if (in_vld[0]) cnt_d = CNT_W'(1);
    else                cnt_d = '0;
    insn_d  = (in_vld[0] && !hit) ? in_insn0 : '0;
    upd_en  = in_vld[0] | vld_q;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q   <= 1'b0;
      fused_q <= 1'b0;
      cnt_q   <= '0;
      insn_q  <= '0;
      uop_q   <= '0;
    end else if (upd_en) begin
      vld_q   <= vld_d;
      fused_q <= fused_d;
      cnt_q   <= cnt_d;
      insn_q  <= insn_d;
      uop_q   <= uop_d;
    end
  end

  assign out_vld      = vld_q;
  assign out_fused    = fused_q;
  assign out_consumed = cnt_q;
  assign out_insn     = insn_q;
  assign out_ld_rd    = uop_q.ld_rd;
  assign out_base     = uop_q.base;
  assign out_idx      = uop_q.idx;
  assign out_shamt    = uop_q.shamt;
  assign out_idx_rd   = uop_q.idx_rd;
  assign out_sum_rd   = uop_q.sum_rd;
  assign out_idx_wen  = uop_q.idx_wen;
  assign out_sum_wen  = uop_q.sum_wen;

endmodule

// File: rtl/fuse_detector_chk.sv
module fuse_detector_chk
  import fuse_pkg::*;
#(
  parameter int unsigned SCALE_SHAMT = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSLOT-1:0]  in_vld,
  input logic              out_vld,
  input logic              out_fused,
  input logic [CNT_W-1:0]  out_consumed,
  input logic [ILEN-1:0]   out_insn,
  input logic [RIDX_W-1:0] out_ld_rd,
  input logic [RIDX_W-1:0] out_base,
  input logic [SHW-1:0]    out_shamt,
  input logic [RIDX_W-1:0] out_idx_rd,
  input logic [RIDX_W-1:0] out_sum_rd,
  input logic              out_idx_wen,
  input logic              out_sum_wen
);

  a_r8_fused_takes_three: assert property (@(posedge clk) disable iff (!rst_n)
    out_fused |-> (out_consumed == CNT_W'(NSLOT) && out_vld));

  a_r7_full_window_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld != {NSLOT{1'b1}}) |=> !out_fused);

  a_r8_empty_slot_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld[0] |=> (!out_vld && out_consumed == '0));

  a_r9_no_passthrough_on_fuse: assert property (@(posedge clk) disable iff (!rst_n)
    out_fused |-> (out_insn == '0));

  a_r9_fields_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !out_fused |-> (out_idx_rd == '0 && out_sum_rd == '0 && !out_idx_wen && !out_sum_wen));

  a_r5_nonzero_dests: assert property (@(posedge clk) disable iff (!rst_n)
    out_fused |-> (out_idx_rd != '0 && out_sum_rd != '0));

  a_r6_base_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    out_fused |-> (out_base != out_idx_rd));

  a_r1_scale_amount: assert property (@(posedge clk) disable iff (!rst_n)
    out_fused |-> (out_shamt == SHW'(SCALE_SHAMT)));

  a_r11_sum_overwritten: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fused && out_sum_rd == out_ld_rd) |-> !out_sum_wen);

endmodule

bind fuse_detector fuse_detector_chk #(.SCALE_SHAMT(SCALE_SHAMT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_vld       (in_vld),
  .out_vld      (out_vld),
  .out_fused    (out_fused),
  .out_consumed (out_consumed),
  .out_insn     (out_insn),
  .out_ld_rd    (out_ld_rd),
  .out_base     (out_base),
  .out_shamt    (out_shamt),
  .out_idx_rd   (out_idx_rd),
  .out_sum_rd   (out_sum_rd),
  .out_idx_wen  (out_idx_wen),
  .out_sum_wen  (out_sum_wen)
);

// File: tb/fuse_detector_tb.sv
module fuse_detector_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [2:0]  in_vld;
  logic [31:0] in_insn0, in_insn1, in_insn2;
  logic        out_vld, out_fused, out_idx_wen, out_sum_wen;
  logic [1:0]  out_consumed;
  logic [31:0] out_insn;
  logic [4:0]  out_ld_rd, out_base, out_idx, out_idx_rd, out_sum_rd;
  logic [5:0]  out_shamt;

  int n_chk = 0;
  int n_err = 0;

  fuse_detector u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .in_insn0(in_insn0), .in_insn1(in_insn1), .in_insn2(in_insn2),
    .out_vld(out_vld), .out_fused(out_fused), .out_consumed(out_consumed),
    .out_insn(out_insn), .out_ld_rd(out_ld_rd), .out_base(out_base),
    .out_idx(out_idx), .out_shamt(out_shamt), .out_idx_rd(out_idx_rd),
    .out_sum_rd(out_sum_rd), .out_idx_wen(out_idx_wen), .out_sum_wen(out_sum_wen)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] enc_shl(input logic [4:0] rd, rs, input logic [5:0] sh);
    return {6'b000000, sh, rs, 3'b001, rd, 7'b0010011};
  endfunction
  function automatic logic [31:0] enc_add(input logic [4:0] rd, r1, r2);
    return {7'b0000000, r2, r1, 3'b000, rd, 7'b0110011};
  endfunction
  function automatic logic [31:0] enc_ldw(input logic [4:0] rd, rs, input logic [11:0] off);
    return {off, rs, 3'b010, rd, 7'b0000011};
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] v, input logic [31:0] i0, i1, i2);
    @(negedge clk);
    in_vld = v; in_insn0 = i0; in_insn1 = i1; in_insn2 = i2;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [32:0] uop_vec();
    return {out_ld_rd, out_base, out_idx, out_shamt, out_idx_rd, out_sum_rd,
            out_idx_wen, out_sum_wen};
  endfunction

  // Compare all outputs against an expectation; fuse_tag names the deciding requirement
  task automatic expect_out(input string tag, input logic [2:0] v, input logic f,
                            input logic [31:0] i0, input logic [32:0] euop);
    logic [1:0] ecnt;
    ecnt = f ? 2'd3 : (v[0] ? 2'd1 : 2'd0);
    chk(tag,  "fused",    {63'd0, out_fused}, {63'd0, f});
    chk("R8", "consumed", {62'd0, out_consumed, ~out_vld ^ v[0]}, {62'd0, ecnt, 1'b1});
    chk("R9", "insn",     {32'd0, out_insn}, {32'd0, (v[0] && !f) ? i0 : 32'd0});
    chk(f ? "R10" : "R9", "fields", {31'd0, uop_vec()}, {31'd0, euop});
  endtask

  // Legal encodings, model from the requirement set
  task automatic run_case(input string tag, input logic [2:0] v, input logic [4:0] t, idx,
                          input logic [5:0] sh, input logic [4:0] a, r1, r2, lrd, lrs);
    logic chained, f;
    logic [4:0] other;
    logic [32:0] eu;
    chained = (r1 == t) || (r2 == t);
    other   = (r1 == t) ? r2 : r1;
    f = (v == 3'b111) && (sh == 6'd2) && (t != 0) && (a != 0) && chained
        && (other != t) && (lrs == a);
    eu = f ? {lrd, other, idx, sh, t, a, (t != a) && (t != lrd), (a != lrd)} : 33'd0;
    apply(v, enc_shl(t, idx, sh), enc_add(a, r1, r2), enc_ldw(lrd, lrs, 12'd0));
    expect_out(tag, v, f, enc_shl(t, idx, sh), eu);
    if (f) chk("R11", "wens", {62'd0, out_idx_wen, out_sum_wen},
               {62'd0, (t != a) && (t != lrd), (a != lrd)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] g0, g1, g2;
    g0 = enc_shl(5'd6, 5'd7, 6'd2);
    g1 = enc_add(5'd8, 5'd9, 5'd6);
    g2 = enc_ldw(5'd10, 5'd8, 12'd0);

    // R12: reset with a fusable window applied
    rst_n = 1'b0; in_vld = 3'b111; in_insn0 = g0; in_insn1 = g1; in_insn2 = g2;
    repeat (3) @(posedge clk);
    #1;
    chk("R12", "reset outputs", {29'd0, out_vld, out_fused, out_consumed, out_insn},
        64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R12", "sync edge 1", {62'd0, out_vld, out_fused}, 64'd0);
    @(posedge clk); #1;
    chk("R12", "sync edge 2", {62'd0, out_vld, out_fused}, 64'd0);
    @(posedge clk); #1;
    chk("R12", "first live edge", {62'd0, out_vld, out_fused}, {62'd0, 2'b11});

    // Known-good fusion, then idle: R10 and R8
    run_case("R10", 3'b111, 5'd6, 5'd7, 6'd2, 5'd8, 5'd9, 5'd6, 5'd10, 5'd8);
    apply(3'b000, 32'd0, 32'd0, 32'd0);
    expect_out("R8", 3'b000, 1'b0, 32'd0, 33'd0);

    // R7: every valid pattern
    for (int v = 0; v < 8; v++)
      run_case("R7", 3'(v), 5'd6, 5'd7, 6'd2, 5'd8, 5'd6, 5'd9, 5'd3, 5'd8);

    // R1: shift amount sweep
    for (int s = 0; s < 64; s++)
      run_case("R1", 3'b111, 5'd6, 5'd7, 6'(s), 5'd8, 5'd6, 5'd9, 5'd3, 5'd8);

    // R4: add does not consume the shift result
    run_case("R4", 3'b111, 5'd6, 5'd7, 6'd2, 5'd8, 5'd11, 5'd12, 5'd3, 5'd8);

    // Main sweep: R2 order, R3 chain, R5 zero dests, R6 clash, R11 enables
    for (int t = 0; t < 4; t++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int ls = 0; ls < 4; ls++)
            for (int ix = 1; ix < 4; ix += 2)
              for (int lr = 0; lr < 3; lr += 2)
                for (int ord = 0; ord < 2; ord++)
                  run_case((t == 0 || a == 0) ? "R5" : (b == t) ? "R6" :
                           (ls != a) ? "R3" : ord ? "R2" : "R10",
                           3'b111, 5'(t), 5'(ix), 6'd2, 5'(a),
                           ord ? 5'(b) : 5'(t), ord ? 5'(t) : 5'(b), 5'(lr), 5'(ls));

    // Encoding breaks: each must pass slot 0 through unfused
    apply(3'b111, g0 | 32'h4000_0000, g1, g2);
    expect_out("R1", 3'b111, 1'b0, g0 | 32'h4000_0000, 33'd0);
    apply(3'b111, g0 ^ 32'h0000_0020, g1, g2);
    expect_out("R1", 3'b111, 1'b0, g0 ^ 32'h0000_0020, 33'd0);
    apply(3'b111, g0, g1 | 32'h4000_0000, g2);
    expect_out("R2", 3'b111, 1'b0, g0, 33'd0);
    apply(3'b111, g0, g1 | 32'h0000_1000, g2);
    expect_out("R2", 3'b111, 1'b0, g0, 33'd0);
    apply(3'b111, g0, g1, g2 & ~32'h0000_2000);
    expect_out("R3", 3'b111, 1'b0, g0, 33'd0);
    apply(3'b111, g0, g1, enc_ldw(5'd10, 5'd8, 12'd4));
    expect_out("R3", 3'b111, 1'b0, g0, 33'd0);
    apply(3'b111, g0, g1, enc_ldw(5'd10, 5'd8, 12'h800));
    expect_out("R3", 3'b111, 1'b0, g0, 33'd0);

    // Back-to-back fusions then pass-through
    run_case("R10", 3'b111, 5'd1, 5'd2, 6'd2, 5'd3, 5'd1, 5'd4, 5'd5, 5'd3);
    run_case("R11", 3'b111, 5'd1, 5'd2, 6'd2, 5'd1, 5'd4, 5'd1, 5'd1, 5'd1);
    run_case("R9", 3'b001, 5'd1, 5'd2, 6'd2, 5'd3, 5'd1, 5'd4, 5'd5, 5'd3);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule